// File: doc/BRIEF.md
# Zero-Word Bit-Vector Builder with Insertion Gate

This block sits on the fill path of a small zero-value tracking structure. A fetched memory block arrives as a stream of 64-bit beats. The block turns that stream into a bit vector in which a 1 marks a zero-valued unit. The unit is either a byte or a 4-byte word, chosen per block. Alongside the vector it counts the zero-valued 4-byte words. It then decides whether the block is worth keeping, by comparing that count with a threshold code that selects 0%, 50% or 100% of the block's words.

A block starts with a one-cycle `start` pulse while the builder is idle. The granularity and the threshold code are sampled on that same edge. Beats are then accepted on every cycle that `beat_valid` is high, with idle gaps allowed, until the block's beat count has been taken. Zero detection is one registered stage and accumulation is a second. The result therefore appears, with a one-cycle `done` strobe, two cycles after the last beat. The vector, count and flag then hold until the next `start`. Updates driven by completed stores go straight to the tracker and never pass through this block.

The controller has four states. ST_IDLE waits for `start`; the transition to ST_RECV clears all results. ST_RECV accepts beats; accepting the final beat moves it to ST_DRAIN. ST_DRAIN lets the final beat pass through the detection stage and always moves on to ST_REPORT. ST_REPORT raises `done` for its single cycle and always returns to ST_IDLE.

Top module: `zero_vector_builder`

## Requirements
- R1: After reset, `zero_vec`, `zero_cnt`, `insert` and `done` are all 0.
- R2: In byte mode (`gran_word`=0), bit 8*b+j of `zero_vec` is 1 exactly when byte lane j (bits 8j+7:8j) of the b-th accepted beat is zero. Beats are numbered from 0.
- R3: In word mode (`gran_word`=1), bit 2*b of `zero_vec` is 1 exactly when bits 31:0 of beat b are zero, and bit 2*b+1 is 1 exactly when bits 63:32 of beat b are zero. Bits 64 to 255 read 0.
- R4: `zero_cnt` equals the number of zero-valued 4-byte words in the block, in both modes, in the range 0 to 64.
- R5: With `thr_sel`=0 (0%), `insert` is 1 for every block.
- R6: With `thr_sel`=1 (50%), `insert` is 1 exactly when `zero_cnt` is at least 32. Exactly 32 inserts.
- R7: With `thr_sel`=2 or 3 (100%), `insert` is 1 exactly when `zero_cnt` is 64.
- R8: `done` is high for exactly one cycle. That cycle is the second cycle after the cycle in which the 32nd beat was accepted, whatever the gaps between beats.
- R9: After `done`, the results hold unchanged until a `start` is accepted. On the cycle after an accepted `start`, all three results read 0.
- R10: `beat_valid` pulses while idle or after the 32nd beat change no result and raise no `done`.
- R11: Changes to `gran_word` and `thr_sel` after `start` have no effect on the block being built.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new block (accepted while idle) |
| gran_word | input | 1 | 0: one bit per byte, 1: one bit per 4-byte word |
| thr_sel | input | 2 | 0: 0%, 1: 50%, 2 or 3: 100% |
| beat_valid | input | 1 | A beat is present on beat_data |
| beat_data | input | 64 | Beat payload, lowest address in bits 7:0 |
| zero_vec | output | 256 | Zero bit vector, filled from bit 0 in address order |
| zero_cnt | output | 7 | Count of zero 4-byte words |
| insert | output | 1 | Block qualifies for insertion |
| done | output | 1 | One-cycle result strobe |

## Verification
Six data patterns are used, each run under several granularity and threshold settings:
- An all-zero block and a block with no zero byte pin the two ends of the count and of every threshold.
- A pattern whose upper words hold a single non-zero byte separates byte from word granularity, since the two modes give very different vectors.
- Blocks with 32, 31 and 63 zero words sit on either side of the 50% and 100% boundaries.

Runs with idle gaps between beats, with the settings changed mid-block, and with stray beats before start and after the last beat show that `done` timing counts accepted beats and that the sampled settings and the results are protected.

// File: rtl/zdv_pkg.sv
package zdv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RECV   = 2'd1,
        ST_DRAIN  = 2'd2,
        ST_REPORT = 2'd3
    } zdv_state_e;

    localparam logic [1:0] THR_ZERO = 2'd0;
    localparam logic [1:0] THR_HALF = 2'd1;
endpackage

// File: rtl/zdv_ctrl.sv
module zdv_ctrl
    import zdv_pkg::*;
#(
    parameter int BEATS = 32,
    localparam int IDX_W = $clog2(BEATS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             beat_valid,
    output logic             take_beat,
    output logic             last_beat,
    output logic [IDX_W-1:0] beat_idx,
    output logic             clear,
    output logic             done
);
    zdv_state_e state_q, state_nx;
    logic [IDX_W-1:0] idx_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_nx = ST_RECV;
            ST_RECV:   if (beat_valid && idx_q == IDX_W'(BEATS-1)) state_nx = ST_DRAIN;
            ST_DRAIN:  state_nx = ST_REPORT;
            ST_REPORT: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                     idx_q <= '0;
        else if (state_q == ST_IDLE)    idx_q <= '0;
        else if (take_beat)             idx_q <= idx_q + 1'b1;
    end

    // outputs
    always_comb begin
        take_beat = 1'b0;
        clear     = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:   clear     = start;
            ST_RECV:   take_beat = beat_valid;
            ST_DRAIN:  ;
            ST_REPORT: done      = 1'b1;
        endcase
        last_beat = take_beat && idx_q == IDX_W'(BEATS-1);
        beat_idx  = idx_q;
    end

    // R8
    done_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(state_q) == ST_DRAIN);

    // R10
    idle_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !take_beat);
endmodule

// File: rtl/zdv_detect.sv
module zdv_detect #(
    parameter int BEAT_W = 64,
    parameter int IDX_W  = 5,
    localparam int BPB   = BEAT_W / 8,
    localparam int WPB   = BEAT_W / 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_v,
    input  logic              in_last,
    input  logic [IDX_W-1:0]  in_idx,
    input  logic [BEAT_W-1:0] in_data,
    output logic              p_v,
    output logic              p_last,
    output logic [IDX_W-1:0]  p_idx,
    output logic [BPB-1:0]    p_byte_z,
    output logic [WPB-1:0]    p_word_z
);
    logic [BPB-1:0] byte_z;
    logic [WPB-1:0] word_z;

    for (genvar j = 0; j < BPB; j++) begin : g_byte
        assign byte_z[j] = (in_data[8*j +: 8] == 8'h00);
    end
    for (genvar k = 0; k < WPB; k++) begin : g_word
        assign word_z[k] = (in_data[32*k +: 32] == 32'h0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_v      <= 1'b0;
            p_last   <= 1'b0;
            p_idx    <= '0;
            p_byte_z <= '0;
            p_word_z <= '0;
        end else begin
            p_v    <= in_v;
            p_last <= in_last;
            if (in_v) begin
                p_idx    <= in_idx;
                p_byte_z <= byte_z;
                p_word_z <= word_z;
            end
        end
    end

    // R4
    word_needs_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p_v && p_word_z[0] |-> (p_byte_z[3:0] == 4'hF));
endmodule

// File: rtl/zdv_accum.sv
module zdv_accum #(
    parameter int BLOCK_BYTES = 256,
    parameter int BEAT_W      = 64,
    parameter int IDX_W       = 5,
    localparam int BPB        = BEAT_W / 8,
    localparam int WPB        = BEAT_W / 32,
    localparam int WORDS      = BLOCK_BYTES / 4,
    localparam int CNT_W      = $clog2(WORDS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   gran_word,
    input  logic [1:0]             thr_code,
    input  logic                   p_v,
    input  logic                   p_last,
    input  logic [IDX_W-1:0]       p_idx,
    input  logic [BPB-1:0]         p_byte_z,
    input  logic [WPB-1:0]         p_word_z,
    output logic [BLOCK_BYTES-1:0] vec,
    output logic [CNT_W-1:0]       cnt,
    output logic                   insert
);
    import zdv_pkg::*;

    logic [BLOCK_BYTES-1:0] vec_nx;
    logic [CNT_W-1:0]       cnt_nx;
    logic                   pass_nx;

    always_comb begin
        vec_nx = vec;
        if (gran_word) begin
            for (int k = 0; k < WPB; k++) vec_nx[int'(p_idx) * WPB + k] = p_word_z[k];
        end else begin
            for (int j = 0; j < BPB; j++) vec_nx[int'(p_idx) * BPB + j] = p_byte_z[j];
        end
        cnt_nx = cnt;
        for (int k = 0; k < WPB; k++) cnt_nx = cnt_nx + CNT_W'(p_word_z[k]);
        if (thr_code == THR_ZERO)      pass_nx = 1'b1;
        else if (thr_code == THR_HALF) pass_nx = (cnt_nx >= CNT_W'(WORDS / 2));
        else                           pass_nx = (cnt_nx == CNT_W'(WORDS));
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            vec    <= '0;
            cnt    <= '0;
            insert <= 1'b0;
        end else if (p_v) begin
            vec <= vec_nx;
            cnt <= cnt_nx;
            if (p_last) insert <= pass_nx;
        end
    end

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(WORDS));

    // R7
    full_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(insert) && thr_code[1] |-> cnt == CNT_W'(WORDS));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear && !p_v |=> $stable(vec) && $stable(cnt) && $stable(insert));
endmodule

// File: rtl/zero_vector_builder.sv
module zero_vector_builder #(
    parameter int BEAT_W      = 64,
    parameter int BLOCK_BYTES = 256,
    localparam int BEATS      = BLOCK_BYTES * 8 / BEAT_W,
    localparam int IDX_W      = $clog2(BEATS),
    localparam int BPB        = BEAT_W / 8,
    localparam int WPB        = BEAT_W / 32,
    localparam int CNT_W      = $clog2(BLOCK_BYTES / 4 + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   gran_word,
    input  logic [1:0]             thr_sel,
    input  logic                   beat_valid,
    input  logic [BEAT_W-1:0]      beat_data,
    output logic [BLOCK_BYTES-1:0] zero_vec,
    output logic [CNT_W-1:0]       zero_cnt,
    output logic                   insert,
    output logic                   done
);
    logic             take_beat, last_beat, clear;
    logic [IDX_W-1:0] beat_idx;
    logic             cfg_word_q;
    logic [1:0]       cfg_thr_q;
    logic             p_v, p_last;
    logic [IDX_W-1:0] p_idx;
    logic [BPB-1:0]   p_byte_z;
    logic [WPB-1:0]   p_word_z;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_word_q <= 1'b0;
            cfg_thr_q  <= 2'd0;
        end else if (clear) begin
            cfg_word_q <= gran_word;
            cfg_thr_q  <= thr_sel;
        end
    end

    zdv_ctrl #(.BEATS(BEATS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .beat_valid(beat_valid),
        .take_beat(take_beat), .last_beat(last_beat), .beat_idx(beat_idx),
        .clear(clear), .done(done)
    );

    zdv_detect #(.BEAT_W(BEAT_W), .IDX_W(IDX_W)) u_detect (
        .clk(clk), .rst_n(rst_n), .in_v(take_beat), .in_last(last_beat),
        .in_idx(beat_idx), .in_data(beat_data), .p_v(p_v), .p_last(p_last),
        .p_idx(p_idx), .p_byte_z(p_byte_z), .p_word_z(p_word_z)
    );

    zdv_accum #(.BLOCK_BYTES(BLOCK_BYTES), .BEAT_W(BEAT_W), .IDX_W(IDX_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .clear(clear), .gran_word(cfg_word_q),
        .thr_code(cfg_thr_q), .p_v(p_v), .p_last(p_last), .p_idx(p_idx),
        .p_byte_z(p_byte_z), .p_word_z(p_word_z), .vec(zero_vec),
        .cnt(zero_cnt), .insert(insert)
    );

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    zero_thr_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && cfg_thr_q == 2'd0 |-> insert);

    // R3
    word_mode_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && cfg_word_q |-> zero_vec[BLOCK_BYTES-1:BLOCK_BYTES/4] == '0);
endmodule

// File: tb/test_zero_vector_builder.sv
module test_zero_vector_builder;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         gran_word = 1'b0;
    logic [1:0]   thr_sel = 2'd0;
    logic         beat_valid = 1'b0;
    logic [63:0]  beat_data = '0;
    logic [255:0] zero_vec;
    logic [6:0]   zero_cnt;
    logic         insert;
    logic         done;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    zero_vector_builder i_zero_vector_builder (
        .clk(clk), .rst_n(rst_n), .start(start), .gran_word(gran_word),
        .thr_sel(thr_sel), .beat_valid(beat_valid), .beat_data(beat_data),
        .zero_vec(zero_vec), .zero_cnt(zero_cnt), .insert(insert), .done(done)
    );

    // kind, gran, thr, expected count, expected insert
    localparam int TBL [12][5] = '{
        '{0, 0, 2, 64, 1}, '{0, 1, 1, 64, 1}, '{1, 0, 0,  0, 1},
        '{1, 1, 1,  0, 0}, '{2, 0, 1, 32, 1}, '{2, 1, 2, 32, 0},
        '{3, 1, 1, 32, 1}, '{4, 0, 1, 31, 0}, '{4, 1, 0, 31, 1},
        '{5, 0, 2, 63, 0}, '{5, 1, 3, 63, 0}, '{0, 1, 3, 64, 1}
    };

    function automatic logic [63:0] gen(int kind, int b);
        case (kind)
            0: return 64'h0;
            1: return 64'h0123_4567_89AB_CDEF;
            2: return 64'h00FF_0000_0000_0000;
            3: return (b < 16) ? 64'h0 : 64'h1111_1111_2222_2222;
            4: return (b < 15) ? 64'h0 : (b == 15 ? 64'h0000_0001_0000_0000 : 64'h3333_3333_4444_4444);
            default: return (b == 31) ? 64'h8000_0000_0000_0000 : 64'h0;
        endcase
    endfunction

    function automatic logic [255:0] model_vec(int kind, int gran);
        logic [255:0] v = '0;
        for (int b = 0; b < 32; b++) begin
            logic [63:0] d = gen(kind, b);
            if (gran == 0) begin
                for (int j = 0; j < 8; j++) v[8*b+j] = (d[8*j +: 8] == 8'h0);
            end else begin
                v[2*b]   = (d[31:0] == 32'h0);
                v[2*b+1] = (d[63:32] == 32'h0);
            end
        end
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(int kind, int gran, int thr, int ecnt, int eins, bit gap, bit flip, bit extra);
        logic [255:0] ev = model_vec(kind, gran);
        string rq_v = (gran == 0) ? "R2 vector" : "R3 vector";
        string rq_i = (thr == 0) ? "R5 insert" : (thr == 1 ? "R6 insert" : "R7 insert");
        @(negedge clk);
        start = 1'b1; gran_word = gran[0]; thr_sel = thr[1:0];
        @(negedge clk);
        start = 1'b0;
        chk(zero_vec == '0 && zero_cnt == 0 && !insert, "R9 clear on start", {zero_cnt, insert}, '0);
        if (flip) begin gran_word = ~gran_word; thr_sel = ~thr_sel; end // R11
        for (int b = 0; b < 32; b++) begin
            if (gap && (b % 3 == 1)) begin
                beat_valid = 1'b0;
                @(negedge clk);
            end
            beat_valid = 1'b1;
            beat_data = gen(kind, b);
            @(negedge clk);
        end
        beat_valid = extra; // R10 stray beat after the last one
        beat_data = 64'h0;
        chk(!done, "R8 done early", done, 0);
        @(negedge clk);
        beat_valid = 1'b0;
        chk(done, "R8 done on second cycle", done, 1);
        chk(zero_vec == ev, rq_v, zero_vec, ev);
        chk(zero_cnt == ecnt[6:0], "R4 count", zero_cnt, ecnt);
        chk(insert == eins[0], rq_i, insert, eins);
        if (flip) chk(zero_vec == ev && insert == eins[0], "R11 settings sampled", zero_vec, ev);
        @(negedge clk);
        chk(!done, "R8 done one cycle", done, 0);
        chk(zero_vec == ev && zero_cnt == ecnt[6:0] && insert == eins[0], "R9 hold", zero_vec, ev);
        if (extra) chk(zero_vec == ev && zero_cnt == ecnt[6:0], "R10 late beat ignored", zero_cnt, ecnt);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R8 watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(zero_vec == '0 && zero_cnt == 0 && !insert && !done, "R1 reset state",
            {zero_cnt, insert, done}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(zero_vec == '0 && !done, "R1 after release", zero_vec, '0);

        for (int i = 0; i < 12; i++) begin
            run(TBL[i][0], TBL[i][1], TBL[i][2], TBL[i][3], TBL[i][4],
                bit'(i % 2), bit'(i % 3 == 0), bit'(i % 4 == 1));
        end

        // R10: beats while idle leave the last result in place
        begin
            logic [255:0] ev = model_vec(0, 1);
            for (int c = 0; c < 4; c++) begin
                beat_valid = 1'b1;
                beat_data = 64'hFFFF_FFFF_FFFF_FFFF;
                @(negedge clk);
                chk(!done, "R10 idle beat no done", done, 0);
            end
            beat_valid = 1'b0;
            repeat (3) @(negedge clk);
            chk(zero_vec == ev && zero_cnt == 7'd64 && insert, "R10 idle beats ignored", zero_vec, ev);
            chk(!done, "R10 no spurious done", done, 0);
        end

        // R9: long hold, then a new block clears the result
        repeat (20) @(negedge clk);
        chk(zero_cnt == 7'd64 && insert, "R9 long hold", zero_cnt, 64);
        run(4, 1, 1, 31, 0, 1'b1, 1'b0, 1'b1);
        run(3, 0, 1, 32, 1, 1'b0, 1'b1, 1'b0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule